// File: doc/BRIEF.md
# V/f Space-Vector Duration Calculator

This block turns a 4-bit speed command into the timing data for space-vector modulation of a three-phase inverter. A rotating angle is kept in a phase accumulator. Each time the half-period strobe arrives, the accumulator moves forward by a step proportional to the command. The angle is then split into one of six 60° sectors and a position inside that sector. A small sine table gives sin(α) and sin(60° − α).

The modulation index follows a constant volts-per-hertz law. It grows linearly with the command and stops at a ceiling, so the two active dwell times never add up to more than the half-period. The block returns the sector and the three dwell times, counted in clock ticks, for one half of the sampling period. They feed a separate pattern sequencer.

Each strobe uses the angle held before that strobe's advance. The results appear together with a one-cycle valid pulse at a fixed latency.

Top module: `vfsv_calc`

## Requirements
- R1: While reset is active and after it is released, valid_o is 0 and sector_o, tx_o, ty_o and tz_o are all 0, and the angle starts at sector 0, position 0.
- R2: valid_o is high for exactly one cycle, on the third rising edge counted from the edge that samples half_strobe high. valid_o is never high without such a strobe. Strobes on consecutive cycles give valid pulses on consecutive cycles.
- R3: Each strobe advances the inner position by freq_cmd × STEP_PER_CODE. The result of that strobe is computed from the angle as it was before the advance.
- R4: The inner position counts 0 to 2^(ALPHA_BITS+FRAC_W) − 1. When an advance crosses the top of this range, the sector goes up by one, wrapping from 5 to 0. sector_o never exceeds 5.
- R5: The sine index k is the top ALPHA_BITS bits of the inner position, so α = k × 3.75° with the defaults. The sine table holds round(sin(k × 3.75°) × 32768) for k = 0..16. sin(60° − α) is read at entry 16 − k.
- R6: The modulation index is m = freq_cmd × M_PER_CODE, saturated at M_MAX. Here 2^MW represents an index of 1.0.
- R7: tx_o = floor(m × THALF × S[16−k] / 2^(MW+15)) and ty_o = floor(m × THALF × S[k] / 2^(MW+15)), where S is the sine table.
- R8: tz_o = THALF − tx_o − ty_o, clamped at 0. On every valid pulse, tx_o + ty_o + tz_o = THALF.
- R9: Between valid pulses, all result outputs hold their last values, even when freq_cmd changes.
- R10: A command of 0 gives tx_o = ty_o = 0 and tz_o = THALF, and it leaves the angle unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| freq_cmd | input | FREQ_W | Speed command, sampled on the strobe edge |
| half_strobe | input | 1 | One-cycle pulse once per half sampling period |
| sector_o | output | 3 | Sector 0..5 of the reference vector |
| tx_o | output | TW | First active-vector dwell time, in ticks |
| ty_o | output | TW | Second active-vector dwell time, in ticks |
| tz_o | output | TW | Zero-vector dwell time, in ticks |
| valid_o | output | 1 | One-cycle pulse when the results are new |

## Verification
All four results and the valid pulse are due together, three rising edges after the edge that samples half_strobe. Each bench task drives its inputs 1 ns after an edge. It then waits for that exact edge count and samples 1 ns after the edge, so a result is never read during the cycle in which it changes. The cycle after each pulse is also sampled, to confirm that valid drops and the values hold. In the back-to-back case, three consecutive strobes are checked against three consecutive sampling points. The bench works out the expected angle, the sine values (from real-valued sine) and the dwell times on its own.

// File: rtl/vfsv_pkg.sv
package vfsv_pkg;

   localparam int SIN_FRAC = 15;
   localparam int SIN_W    = 16;
   localparam int LUT_LAST = 16;

   // round(sin(k * 3.75 deg) * 2^15), k = 0..16 covers 0..60 deg
   function automatic logic [SIN_W-1:0] sine_lut(input logic [4:0] k);
      logic [SIN_W-1:0] v;
      case (k)
         5'd0:    v = 16'd0;
         5'd1:    v = 16'd2143;
         5'd2:    v = 16'd4277;
         5'd3:    v = 16'd6393;
         5'd4:    v = 16'd8481;
         5'd5:    v = 16'd10533;
         5'd6:    v = 16'd12540;
         5'd7:    v = 16'd14493;
         5'd8:    v = 16'd16384;
         5'd9:    v = 16'd18205;
         5'd10:   v = 16'd19948;
         5'd11:   v = 16'd21605;
         5'd12:   v = 16'd23170;
         5'd13:   v = 16'd24636;
         5'd14:   v = 16'd25997;
         5'd15:   v = 16'd27246;
         5'd16:   v = 16'd28378;
         default: v = 16'd0;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/vfsv_phase.sv
module vfsv_phase #(
   parameter int FREQ_W = 4,
   parameter int SEC_W  = 12,
   parameter int STEP   = 200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic [FREQ_W-1:0] freq,
   output logic [2:0]        sector,
   output logic [SEC_W-1:0]  inner
);
   localparam int SW = SEC_W + 1;

   logic [SW-1:0] sum;
   logic          wrap;

   always_comb begin
      sum  = SW'(inner) + SW'(freq) * SW'(STEP);
      wrap = sum[SEC_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sector <= 3'd0;
         inner  <= '0;
      end else if (adv) begin
         inner <= sum[SEC_W-1:0];
         if (wrap) sector <= (sector == 3'd5) ? 3'd0 : sector + 3'd1;
      end
   end

   // R4: sector register stays inside 0..5
   p_sector_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sector <= 3'd5);

   // R10: zero command leaves the angle where it was
   p_zero_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && freq == '0) |=> ($stable(inner) && $stable(sector)));

endmodule

// File: rtl/vfsv_vf.sv
module vfsv_vf #(
   parameter int FREQ_W     = 4,
   parameter int MW         = 12,
   parameter int M_PER_CODE = 300,
   parameter int M_MAX      = 4096
) (
   input  logic [FREQ_W-1:0] freq,
   output logic [MW:0]       m
);
   localparam int MWP     = MW + 1;
   localparam int RAW_TOP = M_PER_CODE * ((1 << FREQ_W) - 1);

   logic [31:0] raw;
   always_comb raw = 32'(freq) * 32'(M_PER_CODE);

   generate
      if (RAW_TOP > M_MAX) begin : g_sat
         always_comb m = (raw > 32'(M_MAX)) ? MWP'(M_MAX) : MWP'(raw);
      end else begin : g_lin
         always_comb m = MWP'(raw);
      end
   endgenerate

endmodule

// File: rtl/vfsv_dwell.sv
module vfsv_dwell
   import vfsv_pkg::*;
#(
   parameter int MW         = 12,
   parameter int M_MAX      = 4096,
   parameter int THALF      = 800,
   parameter int TW         = 10,
   parameter int ALPHA_BITS = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  go,
   input  logic [2:0]            sector_in,
   input  logic [ALPHA_BITS-1:0] k_in,
   input  logic [MW:0]           m_in,
   output logic [2:0]            sector_o,
   output logic [TW-1:0]         tx_o,
   output logic [TW-1:0]         ty_o,
   output logic [TW-1:0]         tz_o,
   output logic                  valid_o
);
   localparam int PW    = MW + 1 + TW + SIN_W;
   localparam int SHIFT = MW + SIN_FRAC;

   // stage 1: table reads and operand capture
   logic [SIN_W-1:0] s_a1, s_b1;
   logic [MW:0]      m1;
   logic [2:0]       sec1;
   logic             v1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s_a1 <= '0; s_b1 <= '0; m1 <= '0; sec1 <= 3'd0; v1 <= 1'b0;
      end else begin
         v1 <= go;
         if (go) begin
            s_a1 <= sine_lut(5'(k_in));
            s_b1 <= sine_lut(5'(LUT_LAST) - 5'(k_in));
            m1   <= m_in;
            sec1 <= sector_in;
         end
      end
   end

   // stage 2: scaled products
   logic [PW-1:0] px, py;
   logic [TW-1:0] tx2, ty2;
   logic [2:0]    sec2;
   logic          v2;

   always_comb begin
      px = PW'(m1) * PW'(THALF) * PW'(s_b1);
      py = PW'(m1) * PW'(THALF) * PW'(s_a1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx2 <= '0; ty2 <= '0; sec2 <= 3'd0; v2 <= 1'b0;
      end else begin
         v2 <= v1;
         if (v1) begin
            tx2  <= TW'(px >> SHIFT);
            ty2  <= TW'(py >> SHIFT);
            sec2 <= sec1;
         end
      end
   end

   // stage 3: zero-vector time and output registers
   logic [TW:0]   act_sum;
   logic [TW-1:0] tz_c;

   always_comb begin
      act_sum = {1'b0, tx2} + {1'b0, ty2};
      tz_c    = (act_sum > (TW+1)'(THALF)) ? '0 : TW'((TW+1)'(THALF) - act_sum);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_o <= '0; ty_o <= '0; tz_o <= '0; sector_o <= 3'd0; valid_o <= 1'b0;
      end else begin
         valid_o <= v2;
         if (v2) begin
            tx_o     <= tx2;
            ty_o     <= ty2;
            tz_o     <= tz_c;
            sector_o <= sec2;
         end
      end
   end

   // R2: a result only appears three edges after a strobe
   p_valid_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> $past(go, 3));

   // R6: captured index never passes the ceiling
   p_m_ceiling_r6: assert property (@(posedge clk) disable iff (!rst_n)
      v1 |-> (32'(m1) <= 32'(M_MAX)));

   // R8: the three times fill the half period exactly
   p_time_sum_r8: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (32'(tx_o) + 32'(ty_o) + 32'(tz_o) == 32'(THALF)));

   // R9: results hold while no new result is flagged
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> ($stable(tx_o) && $stable(ty_o) && $stable(tz_o) && $stable(sector_o)));

endmodule

// File: rtl/vfsv_calc.sv
module vfsv_calc #(
   parameter int FREQ_W        = 4,
   parameter int ALPHA_BITS    = 4,
   parameter int FRAC_W        = 8,
   parameter int STEP_PER_CODE = 200,
   parameter int MW            = 12,
   parameter int M_PER_CODE    = 300,
   parameter int M_MAX         = 4096,
   parameter int THALF         = 800,
   localparam int TW           = $clog2(THALF + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FREQ_W-1:0] freq_cmd,
   input  logic              half_strobe,
   output logic [2:0]        sector_o,
   output logic [TW-1:0]     tx_o,
   output logic [TW-1:0]     ty_o,
   output logic [TW-1:0]     tz_o,
   output logic              valid_o
);
   localparam int SEC_W = ALPHA_BITS + FRAC_W;

   generate
      if (ALPHA_BITS != 4) begin : g_bad_alpha
         $error("sine table is built for 16 steps per sector");
      end
      if (STEP_PER_CODE * ((1 << FREQ_W) - 1) >= (1 << SEC_W)) begin : g_bad_step
         $error("largest step must stay below one sector");
      end
      if (M_MAX > (1 << MW)) begin : g_bad_mmax
         $error("index ceiling above 1.0 lets tx+ty exceed the half period");
      end
   endgenerate

   logic [2:0]       sector_q;
   logic [SEC_W-1:0] inner_q;
   logic [MW:0]      m_c;

   vfsv_phase #(.FREQ_W(FREQ_W), .SEC_W(SEC_W), .STEP(STEP_PER_CODE)) u_phase (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv    (half_strobe),
      .freq   (freq_cmd),
      .sector (sector_q),
      .inner  (inner_q)
   );

   vfsv_vf #(.FREQ_W(FREQ_W), .MW(MW), .M_PER_CODE(M_PER_CODE), .M_MAX(M_MAX)) u_vf (
      .freq (freq_cmd),
      .m    (m_c)
   );

   vfsv_dwell #(.MW(MW), .M_MAX(M_MAX), .THALF(THALF), .TW(TW),
                .ALPHA_BITS(ALPHA_BITS)) u_dwell (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (half_strobe),
      .sector_in (sector_q),
      .k_in      (inner_q[SEC_W-1 -: ALPHA_BITS]),
      .m_in      (m_c),
      .sector_o  (sector_o),
      .tx_o      (tx_o),
      .ty_o      (ty_o),
      .tz_o      (tz_o),
      .valid_o   (valid_o)
   );

endmodule

// File: tb/test_vfsv_calc.sv
`timescale 1ns/1ps
module test_vfsv_calc;
   localparam int THALF = 800;
   localparam int TW    = 10;
   localparam int STEP  = 200;
   localparam int MPC   = 300;
   localparam int MMAX  = 4096;
   localparam int INNER_TOP = 4096;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [3:0]    freq_cmd = 4'd0;
   logic          half_strobe = 1'b0;
   logic [2:0]    sector_o;
   logic [TW-1:0] tx_o, ty_o, tz_o;
   logic          valid_o;

   int checks = 0;
   int fails  = 0;
   int m_sec  = 0;
   int m_inn  = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   vfsv_calc #(.THALF(THALF), .STEP_PER_CODE(STEP), .M_PER_CODE(MPC), .M_MAX(MMAX)) i_vfsv_calc (
      .clk(clk), .rst_n(rst_n), .freq_cmd(freq_cmd), .half_strobe(half_strobe),
      .sector_o(sector_o), .tx_o(tx_o), .ty_o(ty_o), .tz_o(tz_o), .valid_o(valid_o)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic longint sval(input int k);
      real r;
      r = $sin(k * 3.14159265358979 / 48.0) * 32768.0;
      return longint'($floor(r + 0.5));
   endfunction

   // expected result for a strobe with command f, then advance the model angle
   task automatic model(input int f, output int es, output int etx, output int ety, output int etz);
      int k;
      longint m;
      k   = m_inn / 256;
      m   = longint'(f) * MPC;
      if (m > MMAX) m = MMAX;
      es  = m_sec;
      etx = int'((m * THALF * sval(16 - k)) >>> 27);
      ety = int'((m * THALF * sval(k)) >>> 27);
      etz = THALF - etx - ety;
      if (etz < 0) etz = 0;
      m_inn = m_inn + f * STEP;
      if (m_inn >= INNER_TOP) begin
         m_inn = m_inn - INNER_TOP;
         m_sec = (m_sec == 5) ? 0 : m_sec + 1;
      end
   endtask

   task automatic check_result(input string req, input int es, input int etx, input int ety, input int etz);
      chk({req, " valid"}, valid_o, 1);
      chk({req, " sector"}, sector_o, es);
      chk({req, " tx"}, tx_o, etx);
      chk({req, " ty"}, ty_o, ety);
      chk({req, " tz"}, tz_o, etz);
   endtask

   task automatic one_strobe(input int f, input string req);
      int es, etx, ety, etz;
      @(posedge clk); #1;
      freq_cmd = 4'(f);
      half_strobe = 1'b1;
      model(f, es, etx, ety, etz);
      @(posedge clk); #1;               // edge 0 samples the strobe
      half_strobe = 1'b0;
      chk("R2 early", valid_o, 0);
      @(posedge clk); #1;
      chk("R2 early", valid_o, 0);
      @(posedge clk); #1;               // third edge: results due
      check_result(req, es, etx, ety, etz);
      @(posedge clk); #1;
      chk("R2 one-shot", valid_o, 0);
   endtask

   task automatic t_reset_r1();
      repeat (3) @(posedge clk);
      #1;
      chk("R1 valid in reset", valid_o, 0);
      chk("R1 sector", sector_o, 0);
      chk("R1 tx", tx_o, 0);
      chk("R1 tz", tz_o, 0);
      rst_n = 1'b1;
      repeat (4) @(posedge clk);
      #1;
      chk("R1 valid after reset", valid_o, 0);
      chk("R1 ty", ty_o, 0);
   endtask

   task automatic t_basic_r3_r7();
      for (int i = 0; i < 6; i++) one_strobe(5, "R3 R5 R7 basic");
      for (int i = 0; i < 4; i++) one_strobe(9, "R3 R7 f9");
   endtask

   task automatic t_sector_wrap_r4();
      for (int i = 0; i < 16; i++) one_strobe(15, "R4 wrap");
   endtask

   task automatic t_saturation_r6();
      one_strobe(13, "R6 below ceiling");
      one_strobe(14, "R6 saturated");
      one_strobe(15, "R6 saturated");
      one_strobe(1, "R6 low index");
   endtask

   task automatic t_zero_r10();
      one_strobe(0, "R10 zero");
      one_strobe(0, "R10 zero again");
      one_strobe(3, "R10 angle kept");
   endtask

   task automatic t_hold_r9();
      int htx, hty, htz, hs;
      htx = tx_o; hty = ty_o; htz = tz_o; hs = sector_o;
      for (int i = 0; i < 8; i++) begin
         @(posedge clk); #1;
         freq_cmd = 4'(i + 7);
         chk("R9 no valid", valid_o, 0);
         chk("R9 tx held", tx_o, htx);
         chk("R9 ty held", ty_o, hty);
         chk("R9 tz held", tz_o, htz);
         chk("R9 sector held", sector_o, hs);
      end
   endtask

   task automatic t_back_to_back_r2();
      int es[3], etx[3], ety[3], etz[3];
      int fs[3] = '{4, 11, 7};
      @(posedge clk); #1;
      for (int c = 0; c < 6; c++) begin
         if (c < 3) begin
            freq_cmd = 4'(fs[c]);
            half_strobe = 1'b1;
            model(fs[c], es[c], etx[c], ety[c], etz[c]);
         end else begin
            half_strobe = 1'b0;
         end
         @(posedge clk); #1;
         if (c >= 2 && c <= 4)
            check_result("R2 back-to-back", es[c-2], etx[c-2], ety[c-2], etz[c-2]);
         if (c == 5) chk("R2 pulses end", valid_o, 0);
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!finished) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      t_reset_r1();
      t_basic_r3_r7();
      t_sector_wrap_r4();
      t_saturation_r6();
      t_hold_r9();
      t_zero_r10();
      t_back_to_back_r2();
      one_strobe(15, "R8 sum");
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule